// File: doc/BRIEF.md
# ADC Code Histogram Linearity Analyzer

This block measures the static linearity of an analog-to-digital converter driven by a slow, linear input ramp. Every valid output code from the converter adds one hit to the bin for that code value. When the ramp is finished, a compute command turns the bin counts into a bin width for each code in fixed point, then a differential nonlinearity (DNL) value and an integral nonlinearity (INL) value for each code, together with the largest absolute DNL and INL.

The two outermost codes catch every input beyond the ends of the range, so their bins have no meaningful width. They are left out of every result. The mean hit count is taken over the interior codes only. Each interior width is the code's count over that mean. DNL is the width less one LSB, and INL is the running sum of DNL. Any interior code with no hits makes DNL equal to -1 LSB and sets a flag. After the done flag rises, software or a test sequencer walks the read address to collect the per-code results.

Top module: `adc_lin_analyzer`

## Requirements
- R1: While the block is idle, each cycle with `code_valid` high adds one to the bin selected by `code_in`, and `rd_count` shows the bin selected by `rd_addr`. Codes presented while `busy` is high are not counted.
- R2: Codes 0 and 2^N-1 are end codes. Their counts are left out of the sum, and their `rd_width` and `rd_dnl` read 0 after a compute.
- R3: With S the sum of the counts of codes 1 to 2^N-2, the width of interior code k is floor(count_k * (2^N-2) * 256 / S). It is unsigned, with the low 8 bits fractional, so 256 is one LSB.
- R4: The DNL of an interior code is its width minus 256, in two's complement with 8 fractional bits.
- R5: An interior code with zero hits reads DNL = -256. `missing` is high after the compute if any interior count was zero, and low otherwise.
- R6: INL at code 1 is 0. INL at code k, for k from 2 to 2^N-1, is the sum of the DNL values of codes 1 to k-1. INL at code 0 reads 0.
- R7: `max_abs_dnl` is the largest |DNL| over codes 1 to 2^N-2. `max_abs_inl` is the largest |INL| over codes 1 to 2^N-1.
- R8: A bin count stops at 65535 and does not wrap.
- R9: `clear_cmd` in an idle cycle zeroes every bin, keeps `busy` high for exactly 2^N cycles, and lowers `done` and `missing`. If both commands arrive in the same cycle, the clear is taken.
- R10: `compute_cmd` in an idle cycle raises `busy` in the next cycle and lowers `done`. When all codes are processed, `busy` falls and `done` rises together. `done` stays high until the next command. After reset, `busy`, `done` and `missing` are low and all bins read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_valid | input | 1 | Qualifies `code_in` for counting |
| code_in | input | CODE_W | Converter output code |
| clear_cmd | input | 1 | Start zeroing all bins |
| compute_cmd | input | 1 | Start post-processing |
| rd_addr | input | CODE_W | Code whose results are read |
| busy | output | 1 | Clear or compute in progress |
| done | output | 1 | Results valid |
| missing | output | 1 | Some interior code had no hits |
| rd_count | output | CNT_W | Hit count of code `rd_addr` |
| rd_width | output | CODE_W+FRAC | Bin width of code `rd_addr`, unsigned, FRAC fractional bits |
| rd_dnl | output | CODE_W+FRAC+1 | DNL of code `rd_addr`, signed |
| rd_inl | output | 2*CODE_W+FRAC+1 | INL of code `rd_addr`, signed |
| max_abs_dnl | output | CODE_W+FRAC+1 | Largest absolute DNL |
| max_abs_inl | output | 2*CODE_W+FRAC+1 | Largest absolute INL |

## Verification
If the running sum S is wrong, every interior width is scaled wrongly. That error shows up as soon as `done` rises, and it grows along the INL read-out because each INL value carries the errors of all the codes below it. An error in indexing or accumulation, such as an end bin included in S or an INL that is off by one code, changes the values read at codes 1, 2^N-2 and 2^N-1. So the bench compares every code against widths, DNL and INL it computes on its own. A counter that wraps or keeps counting while busy shows up at `rd_count` on the first read after the stimulus. The bench therefore reads the counts back after the saturation run and after the codes it sends during a compute.

// File: rtl/adc_lin_pkg.sv
package adc_lin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLR,
        ST_SUM,
        ST_DIV_GO,
        ST_DIV_WAIT,
        ST_FIN
    } lin_state_e;

    // number of codes whose width is defined
    function automatic int interior_codes(input int code_w);
        return (1 << code_w) - 2;
    endfunction

endpackage

// File: rtl/hist_bank.sv
module hist_bank #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inc_en,
    input  logic [CODE_W-1:0] inc_code,
    input  logic              clr_en,
    input  logic [CODE_W-1:0] clr_addr,
    input  logic [CODE_W-1:0] ra_addr,
    output logic [CNT_W-1:0]  ra_data,
    input  logic [CODE_W-1:0] rb_addr,
    output logic [CNT_W-1:0]  rb_data
);
    localparam int NBINS = 1 << CODE_W;
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic [CNT_W-1:0] bins_q [NBINS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBINS; i++) bins_q[i] <= '0;
        end else if (clr_en) begin
            bins_q[clr_addr] <= '0;
        end else if (inc_en && bins_q[inc_code] != CMAX) begin
            bins_q[inc_code] <= bins_q[inc_code] + 1'b1;
        end
    end

    assign ra_data = bins_q[ra_addr];
    assign rb_data = bins_q[rb_addr];
endmodule

// File: rtl/seq_divider.sv
module seq_divider #(
    parameter int NUM_W = 30,
    parameter int DEN_W = 22
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             done
);
    localparam int STEP_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0]  rem_q, den_q;
    logic [NUM_W-1:0]  nq_q;
    logic [STEP_W-1:0] step_q;
    logic              run_q;
    logic [DEN_W:0]    trial;
    logic              fits;

    assign trial = {rem_q, nq_q[NUM_W-1]};
    assign fits  = trial >= {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            den_q  <= '0;
            nq_q   <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                den_q  <= den;
                nq_q   <= num;
                step_q <= STEP_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
                nq_q   <= {nq_q[NUM_W-2:0], fits};
                step_q <= step_q - 1'b1;
                if (step_q == STEP_W'(1)) begin
                    run_q <= 1'b0;
                    done  <= 1'b1;
                end
            end
        end
    end

    assign quo = nq_q;
endmodule

// File: rtl/adc_lin_analyzer.sv
module adc_lin_analyzer
    import adc_lin_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16,
    parameter int FRAC   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           code_valid,
    input  logic [CODE_W-1:0]              code_in,
    input  logic                           clear_cmd,
    input  logic                           compute_cmd,
    input  logic [CODE_W-1:0]              rd_addr,
    output logic                           busy,
    output logic                           done,
    output logic                           missing,
    output logic [CNT_W-1:0]               rd_count,
    output logic [CODE_W+FRAC-1:0]         rd_width,
    output logic signed [CODE_W+FRAC:0]    rd_dnl,
    output logic signed [2*CODE_W+FRAC:0]  rd_inl,
    output logic [CODE_W+FRAC:0]           max_abs_dnl,
    output logic [2*CODE_W+FRAC:0]         max_abs_inl
);
    localparam int NBINS = 1 << CODE_W;
    localparam int NINT  = interior_codes(CODE_W);
    localparam int WID_W = CODE_W + FRAC;
    localparam int DNL_W = WID_W + 1;
    localparam int INL_W = DNL_W + CODE_W;
    localparam int SUM_W = CNT_W + CODE_W;
    localparam int NUM_W = SUM_W + FRAC;
    localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NBINS - 1);
    localparam logic [CODE_W-1:0] LAST_INT  = CODE_W'(NBINS - 2);

    typedef struct packed {
        logic [WID_W-1:0]        width;
        logic signed [DNL_W-1:0] dnl;
        logic signed [INL_W-1:0] inl;
    } lin_res_t;

    lin_state_e              state_q;
    logic [CODE_W-1:0]       idx_q;
    logic [SUM_W-1:0]        sum_q;
    logic signed [INL_W-1:0] inl_acc_q;
    logic                    done_q, miss_q;
    logic [DNL_W-1:0]        mdnl_q;
    logic [INL_W-1:0]        minl_q;
    lin_res_t                res_q [NBINS];

    logic [CNT_W-1:0]        cnt_idx;
    logic [NUM_W-1:0]        div_num, div_quo;
    logic                    div_done;
    logic [WID_W-1:0]        w_new;
    logic signed [DNL_W-1:0] dnl_new;
    logic signed [INL_W-1:0] inl_new;
    logic [DNL_W-1:0]        dnl_mag;
    logic [INL_W-1:0]        inl_mag;

    hist_bank #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .inc_en   (code_valid && state_q == ST_IDLE),
        .inc_code (code_in),
        .clr_en   (state_q == ST_CLR),
        .clr_addr (idx_q),
        .ra_addr  (idx_q),
        .ra_data  (cnt_idx),
        .rb_addr  (rd_addr),
        .rb_data  (rd_count)
    );

    assign div_num = (NUM_W'(cnt_idx) * NUM_W'(NINT)) << FRAC;

    seq_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (state_q == ST_DIV_GO),
        .num   (div_num),
        .den   (sum_q),
        .quo   (div_quo),
        .done  (div_done)
    );

    always_comb begin
        w_new   = (sum_q == '0) ? '0 : div_quo[WID_W-1:0];
        dnl_new = DNL_W'({1'b0, w_new}) - DNL_W'(1 << FRAC);
        inl_new = inl_acc_q + {{(INL_W-DNL_W){dnl_new[DNL_W-1]}}, dnl_new};
        dnl_mag = dnl_new[DNL_W-1] ? DNL_W'(-dnl_new) : DNL_W'(dnl_new);
        inl_mag = inl_new[INL_W-1] ? INL_W'(-inl_new) : INL_W'(inl_new);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            sum_q     <= '0;
            inl_acc_q <= '0;
            done_q    <= 1'b0;
            miss_q    <= 1'b0;
            mdnl_q    <= '0;
            minl_q    <= '0;
            for (int i = 0; i < NBINS; i++) res_q[i] <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (clear_cmd) begin
                        state_q <= ST_CLR;
                        idx_q   <= '0;
                        done_q  <= 1'b0;
                        miss_q  <= 1'b0;
                    end else if (compute_cmd) begin
                        state_q   <= ST_SUM;
                        idx_q     <= CODE_W'(1);
                        sum_q     <= '0;
                        inl_acc_q <= '0;
                        done_q    <= 1'b0;
                        miss_q    <= 1'b0;
                        mdnl_q    <= '0;
                        minl_q    <= '0;
                        for (int i = 0; i < NBINS; i++) res_q[i] <= '0;
                    end
                end
                ST_CLR: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_CODE) state_q <= ST_IDLE;
                end
                ST_SUM: begin
                    sum_q <= sum_q + SUM_W'(cnt_idx);
                    if (cnt_idx == '0) miss_q <= 1'b1;
                    if (idx_q == LAST_INT) begin
                        state_q <= ST_DIV_GO;
                        idx_q   <= CODE_W'(1);
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_DIV_GO: state_q <= ST_DIV_WAIT;
                ST_DIV_WAIT: begin
                    if (div_done) begin
                        res_q[idx_q].width        <= w_new;
                        res_q[idx_q].dnl          <= dnl_new;
                        res_q[idx_q + 1'b1].inl   <= inl_new;
                        inl_acc_q                 <= inl_new;
                        if (dnl_mag > mdnl_q) mdnl_q <= dnl_mag;
                        if (inl_mag > minl_q) minl_q <= inl_mag;
                        if (idx_q == LAST_INT) begin
                            state_q <= ST_FIN;
                        end else begin
                            idx_q   <= idx_q + 1'b1;
                            state_q <= ST_DIV_GO;
                        end
                    end
                end
                ST_FIN: begin
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = done_q;
    assign missing     = miss_q;
    assign rd_width    = res_q[rd_addr].width;
    assign rd_dnl      = res_q[rd_addr].dnl;
    assign rd_inl      = res_q[rd_addr].inl;
    assign max_abs_dnl = mdnl_q;
    assign max_abs_inl = minl_q;
endmodule

// File: rtl/adc_lin_checker.sv
module adc_lin_checker #(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 16,
    parameter int FRAC   = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           code_valid,
    input logic [CODE_W-1:0]              code_in,
    input logic                           clear_cmd,
    input logic                           compute_cmd,
    input logic [CODE_W-1:0]              rd_addr,
    input logic                           busy,
    input logic                           done,
    input logic                           missing,
    input logic [CNT_W-1:0]               rd_count,
    input logic [CODE_W+FRAC-1:0]         rd_width,
    input logic signed [CODE_W+FRAC:0]    rd_dnl,
    input logic signed [2*CODE_W+FRAC:0]  rd_inl,
    input logic [CODE_W+FRAC:0]           max_abs_dnl,
    input logic [2*CODE_W+FRAC:0]         max_abs_inl
);
    localparam logic [CODE_W-1:0] TOP_CODE = '1;
    localparam logic [CNT_W-1:0]  CMAX     = '1;
    localparam int                DNL_W    = CODE_W + FRAC + 1;

    logic [DNL_W-1:0] rd_dnl_mag;
    assign rd_dnl_mag = rd_dnl[DNL_W-1] ? DNL_W'(-rd_dnl) : DNL_W'(rd_dnl);

    // R2
    end_bin_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (done && (rd_addr == '0 || rd_addr == TOP_CODE)) |-> (rd_width == '0 && rd_dnl == '0));

    // R4
    dnl_floor_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_dnl >= -$signed(DNL_W'(1 << FRAC))));

    // R5
    missing_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rd_addr != '0 && rd_addr != TOP_CODE && rd_count == '0) |-> missing);

    // R6
    inl_start_chk: assert property (@(posedge clk) disable iff (rst)
        (done && rd_addr == CODE_W'(1)) |-> (rd_inl == '0));

    // R7
    dnl_peak_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (max_abs_dnl >= rd_dnl_mag));

    // R8
    count_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_count == CMAX && !busy && !clear_cmd) |=> (rd_count == CMAX || !$stable(rd_addr)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));
endmodule

bind adc_lin_analyzer adc_lin_checker #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC(FRAC)) u_chk (.*);

// File: tb/sim_adc_lin_analyzer.sv
module sim_adc_lin_analyzer;
    localparam int CODE_W = 6;
    localparam int CNT_W  = 16;
    localparam int FRAC   = 8;
    localparam int NB     = 1 << CODE_W;
    localparam int NI     = NB - 2;
    localparam int ONE    = 1 << FRAC;

    logic clk = 1'b0;
    logic rst, code_valid, clear_cmd, compute_cmd;
    logic [CODE_W-1:0] code_in, rd_addr;
    logic busy, done, missing;
    logic [CNT_W-1:0] rd_count;
    logic [CODE_W+FRAC-1:0] rd_width;
    logic signed [CODE_W+FRAC:0] rd_dnl;
    logic signed [2*CODE_W+FRAC:0] rd_inl;
    logic [CODE_W+FRAC:0] max_abs_dnl;
    logic [2*CODE_W+FRAC:0] max_abs_inl;

    always #4 clk = ~clk;

    adc_lin_analyzer #(.CODE_W(CODE_W), .CNT_W(CNT_W), .FRAC(FRAC)) u0 (.*);

    typedef struct {
        int     addr;
        longint cnt;
        longint wid;
        longint dnl;
        longint inl;
    } exp_item_t;

    exp_item_t sb_q[$];
    bit     mon_act = 1'b0;
    int     n_chk = 0, n_fail = 0;
    bit     finished = 1'b0;
    longint mdl [NB];
    longint e_w [NB], e_d [NB], e_i [NB];
    longint e_mdnl, e_minl;
    bit     e_miss;

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic put_code(input int c);
        @(negedge clk);
        code_valid = 1'b1;
        code_in    = CODE_W'(c);
        if (!busy && mdl[c] < 65535) mdl[c]++;
    endtask

    task automatic idle_input();
        @(negedge clk);
        code_valid = 1'b0;
    endtask

    // expected results from the counts alone
    task automatic build_expect();
        longint s = 0, acc = 0;
        e_mdnl = 0; e_minl = 0; e_miss = 1'b0;
        for (int k = 1; k <= NI; k++) s += mdl[k];
        for (int k = 0; k < NB; k++) begin e_w[k] = 0; e_d[k] = 0; e_i[k] = 0; end
        for (int k = 1; k <= NI; k++) begin
            if (mdl[k] == 0) e_miss = 1'b1;
            e_w[k] = (s == 0) ? 0 : (mdl[k] * NI * ONE) / s;
            e_d[k] = e_w[k] - ONE;
            acc += e_d[k];
            e_i[k+1] = acc;
            if ((e_d[k] < 0 ? -e_d[k] : e_d[k]) > e_mdnl) e_mdnl = (e_d[k] < 0 ? -e_d[k] : e_d[k]);
            if ((acc < 0 ? -acc : acc) > e_minl) e_minl = (acc < 0 ? -acc : acc);
        end
    endtask

    // driver side of the scoreboard
    task automatic push_all();
        for (int k = 0; k < NB; k++) begin
            exp_item_t it;
            it.addr = k; it.cnt = mdl[k]; it.wid = e_w[k]; it.dnl = e_d[k]; it.inl = e_i[k];
            sb_q.push_back(it);
        end
        wait (sb_q.size() == 0 && !mon_act);
    endtask

    task automatic run_compute(input string tag);
        @(negedge clk);
        compute_cmd = 1'b1;
        @(negedge clk);
        compute_cmd = 1'b0;
        chk(busy == 1'b1 && done == 1'b0,
            $sformatf("R10 %s busy/done after compute: %0b/%0b exp 1/0", tag, busy, done));
        // codes sent while busy must be dropped (R1)
        for (int i = 0; i < 12; i++) put_code(5);
        idle_input();
        while (!done) @(negedge clk);
        chk(busy == 1'b0, $sformatf("R10 %s busy at done: %0b exp 0", tag, busy));
        build_expect();
        chk(missing == e_miss, $sformatf("R5 %s missing: %0b exp %0b", tag, missing, e_miss));
        chk(longint'(max_abs_dnl) == e_mdnl,
            $sformatf("R7 %s max dnl: %0d exp %0d", tag, max_abs_dnl, e_mdnl));
        chk(longint'(max_abs_inl) == e_minl,
            $sformatf("R7 %s max inl: %0d exp %0d", tag, max_abs_inl, e_minl));
        push_all();
    endtask

    task automatic run_clear();
        int n = 0;
        @(negedge clk);
        clear_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        while (busy) begin n++; @(negedge clk); end
        for (int k = 0; k < NB; k++) mdl[k] = 0;
        chk(n == NB, $sformatf("R9 clear busy cycles: %0d exp %0d", n, NB));
        chk(done == 1'b0 && missing == 1'b0,
            $sformatf("R9 flags after clear: done %0b missing %0b exp 0/0", done, missing));
    endtask

    // monitor side of the scoreboard
    initial begin
        exp_item_t it;
        forever begin
            wait (sb_q.size() != 0);
            it = sb_q.pop_front();
            mon_act = 1'b1;
            @(negedge clk);
            rd_addr = CODE_W'(it.addr);
            #1;
            chk(longint'(rd_count) == it.cnt,
                $sformatf("R1 count code %0d: %0d exp %0d", it.addr, rd_count, it.cnt));
            if (it.addr == 0 || it.addr == NB - 1)
                chk(rd_width == '0 && rd_dnl == '0,
                    $sformatf("R2 end code %0d width/dnl: %0d/%0d exp 0/0", it.addr, rd_width, rd_dnl));
            else
                chk(longint'(rd_width) == it.wid,
                    $sformatf("R3 width code %0d: %0d exp %0d", it.addr, rd_width, it.wid));
            chk(longint'(rd_dnl) == it.dnl,
                $sformatf("R4 dnl code %0d: %0d exp %0d", it.addr, rd_dnl, it.dnl));
            chk(longint'(rd_inl) == it.inl,
                $sformatf("R6 inl code %0d: %0d exp %0d", it.addr, rd_inl, it.inl));
            mon_act = 1'b0;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst = 1'b1; code_valid = 1'b0; code_in = '0;
        clear_cmd = 1'b0; compute_cmd = 1'b0; rd_addr = '0;
        for (int k = 0; k < NB; k++) mdl[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(busy == 0 && done == 0 && missing == 0,
            $sformatf("R10 reset flags: %0b%0b%0b exp 000", busy, done, missing));
        rd_addr = CODE_W'(17);
        #1;
        chk(rd_count == '0, $sformatf("R10 reset count: %0d exp 0", rd_count));

        // pattern A: uneven interior, heavy end bins
        for (int r = 0; r < 40; r++) begin
            for (int k = 0; k < NB; k++) begin
                int want = (k == 0) ? 40 : (k == NB - 1) ? 25 : 3 + ((k * 7) % 5);
                if (r < want) put_code(k);
            end
            if (r % 3 == 0) idle_input();
        end
        idle_input();
        run_compute("A");

        // a clear with a compute in the same cycle: the clear wins (R9)
        @(negedge clk);
        clear_cmd = 1'b1;
        compute_cmd = 1'b1;
        @(negedge clk);
        clear_cmd = 1'b0;
        compute_cmd = 1'b0;
        while (busy) @(negedge clk);
        for (int k = 0; k < NB; k++) mdl[k] = 0;
        chk(done == 1'b0, $sformatf("R9 done after clear+compute: %0b exp 0", done));
        rd_addr = CODE_W'(0);
        #1;
        chk(rd_count == '0, $sformatf("R9 code 0 after clear: %0d exp 0", rd_count));

        // pattern B: a missing code, a wide code, a narrow code
        for (int r = 0; r < 12; r++) begin
            for (int k = 0; k < NB; k++) begin
                int want = (k == 10) ? 0 : (k == 20) ? 12 : (k == 30) ? 1 :
                           (k == 0 || k == NB - 1) ? 7 : 4;
                if (r < want) put_code(k);
            end
        end
        idle_input();
        run_compute("B");

        // pattern C: saturating end bin, flat interior
        run_clear();
        for (int i = 0; i < 65540; i++) put_code(0);
        for (int r = 0; r < 3; r++)
            for (int k = 1; k < NB; k++) put_code(k);
        idle_input();
        rd_addr = CODE_W'(0);
        #1;
        chk(rd_count == 16'hFFFF, $sformatf("R8 saturated count: %0d exp 65535", rd_count));
        run_compute("C");

        finish_run();
    end
endmodule